// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is one arithmetic slice for signal-processing datapaths. It multiplies two 18-bit two's complement operands and folds the product into a 48-bit accumulator. Ahead of the multiplier, an optional pre-adder sums two inputs, so the two samples that share a tap in a symmetric FIR filter need only one multiply. The second operand comes either from an input port or from a small built-in table of sixteen 18-bit coefficients. A dot-product mode treats each operand as two 9-bit signed halves and returns the sum of the two half-products. That is the building step of a complex multiply.

Every input word arrives with `in_valid`. Its controls travel with it through `STAGES` optional pipeline registers (0 to 3). The accumulator register follows them, so a result appears `STAGES+1` cycles after its input, with `out_valid` beside it. A cascade input can be added into the accumulator when it loads. The accumulator value is also driven on a cascade output, so several slices can be chained into a longer sum.

The accumulator is steered by a four-way operation code (`ACC_HOLD`, `ACC_CLEAR`, `ACC_LOAD`, `ACC_ADD`) that is carried with each word. Each accepted word moves the accumulator to one of these:
- No valid word: the accumulator stays in `ACC_HOLD`.
- `acc_clear` set: `ACC_CLEAR`.
- Otherwise `acc_load` set: `ACC_LOAD`.
- Otherwise: `ACC_ADD`.

Top module: `preadd_mac`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `result` and `casc_out` are zero and `out_valid` is low.
- R2: A valid word with `acc_load` set, and the pre-adder, table and dot-product mode all off, sets `result` to the signed product `a_in * b_in`, sign-extended to 48 bits.
- R3: With `preadd_en` set, the first multiplier operand is `a_in + d_in`, taken as a 19-bit signed sum and cut to its low 18 bits. For example, 131071 + 1 becomes -131072.
- R4: With `coef_sel` set, the second operand is table entry `coef_addr` (4 bits) in place of `b_in`. Entry k holds the 18-bit signed value 7919*k - 50000.
- R5: With `dot_mode` set, each operand splits into a signed high half (bits 17:9) and a signed low half (bits 8:0). The term is high*high + low*low.
- R6: A valid word with neither clear nor load adds its term to the accumulator, wrapping modulo 2^48.
- R7: A valid word with `acc_clear` set makes the accumulator zero. Clear wins over load.
- R8: On a load with `casc_en` set, `casc_in` is added to the term. On an accumulate, `casc_in` has no effect.
- R9: `out_valid` is high exactly `STAGES+1` cycles after a valid input. When no valid word reaches the accumulator, `result` keeps its value.
- R10: `casc_out` always equals `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| a_in | input | 18 | First operand, signed |
| b_in | input | 18 | Second operand, signed |
| d_in | input | 18 | Pre-adder addend, signed |
| preadd_en | input | 1 | Use a_in + d_in as first operand |
| coef_sel | input | 1 | Take second operand from the coefficient table |
| coef_addr | input | 4 | Coefficient table index |
| dot_mode | input | 1 | Sum of two 9x9 half-products |
| acc_clear | input | 1 | Zero the accumulator |
| acc_load | input | 1 | Replace the accumulator with the term |
| casc_en | input | 1 | Add casc_in on load |
| casc_in | input | 48 | Cascade input from a neighbouring slice |
| result | output | 48 | Accumulator value |
| out_valid | output | 1 | Result updated this cycle |
| casc_out | output | 48 | Cascade output to the next slice |

## Verification
Pre-add, table lookup and dot-product splitting all act on the same word, and clear and load can both be asserted in one word. The bench deliberately sets these together: pre-add with table operand in dot mode, and clear with load and cascade enable. A behavioural model computes each term with plain integer arithmetic and applies the clear-over-load order. Its accumulator is compared with `result`, `casc_out` and `out_valid` on every clock. Wrap-around is provoked by loading a near-full cascade value and then accumulating past 2^48.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OP_W    = 18;
    localparam int HALF_W  = OP_W / 2;
    localparam int ACC_W   = 48;
    localparam int ROM_AW  = 4;
    localparam int ROM_N   = 1 << ROM_AW;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_CLEAR = 2'd1,
        ACC_LOAD  = 2'd2,
        ACC_ADD   = 2'd3
    } acc_op_e;

    typedef struct packed {
        logic             vld;
        acc_op_e          op;
        logic [ACC_W-1:0] term;
        logic [ACC_W-1:0] casc;
    } mac_pkt_t;

    // Coefficient table entry k = 7919*k - 50000, as 18-bit two's complement.
    function automatic logic [OP_W-1:0] coef_entry(input int idx);
        int v;
        v = 7919 * idx - 50000;
        return v[OP_W-1:0];
    endfunction
endpackage

// File: rtl/mac_operand.sv
module mac_operand
    import mac_pkg::*;
(
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    input  logic [OP_W-1:0]   d_in,
    input  logic              preadd_en,
    input  logic              coef_sel,
    input  logic [ROM_AW-1:0] coef_addr,
    output logic [OP_W-1:0]   a_op,
    output logic [OP_W-1:0]   b_op
);
    logic [OP_W-1:0] coef_tbl [ROM_N];
    logic [OP_W:0]   pre_sum;

    for (genvar k = 0; k < ROM_N; k++) begin : g_tbl
        assign coef_tbl[k] = coef_entry(k);
    end

    always_comb begin
        pre_sum = {a_in[OP_W-1], a_in} + {d_in[OP_W-1], d_in};
        a_op    = preadd_en ? pre_sum[OP_W-1:0] : a_in;
        b_op    = coef_sel ? coef_tbl[coef_addr] : b_in;
    end
endmodule

// File: rtl/mac_multiply.sv
module mac_multiply
    import mac_pkg::*;
(
    input  logic [OP_W-1:0]  a_op,
    input  logic [OP_W-1:0]  b_op,
    input  logic             dot_mode,
    output logic [ACC_W-1:0] term
);
    localparam int PW = 2 * OP_W;
    localparam int HP = 2 * HALF_W;

    logic signed [PW-1:0] full_p;
    logic signed [HP-1:0] hi_a, hi_b, lo_a, lo_b;
    logic signed [HP-1:0] hi_p, lo_p;
    logic signed [HP:0]   dot_sum;

    always_comb begin
        full_p  = $signed(a_op) * $signed(b_op);
        hi_a    = $signed({{HALF_W{a_op[OP_W-1]}},   a_op[OP_W-1:HALF_W]});
        hi_b    = $signed({{HALF_W{b_op[OP_W-1]}},   b_op[OP_W-1:HALF_W]});
        lo_a    = $signed({{HALF_W{a_op[HALF_W-1]}}, a_op[HALF_W-1:0]});
        lo_b    = $signed({{HALF_W{b_op[HALF_W-1]}}, b_op[HALF_W-1:0]});
        hi_p    = hi_a * hi_b;
        lo_p    = lo_a * lo_b;
        dot_sum = {hi_p[HP-1], hi_p} + {lo_p[HP-1], lo_p};
        if (dot_mode)
            term = {{(ACC_W-HP-1){dot_sum[HP]}}, dot_sum};
        else
            term = {{(ACC_W-PW){full_p[PW-1]}}, full_p};
    end

    // R5: two 9x9 signed products never leave [-130560, 131072]
    always_comb begin
        if (dot_mode) begin
            p_dot_range_r5: assert ($signed(term) <= 48'sd131072 &&
                                    $signed(term) >= -48'sd130560);
        end
    end
endmodule

// File: rtl/mac_delay.sv
module mac_delay
    import mac_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  mac_pkt_t pkt_in,
    output mac_pkt_t pkt_out
);
    if (STAGES == 0) begin : g_bypass
        assign pkt_out = pkt_in;
    end else begin : g_pipe
        mac_pkt_t stage_q [STAGES];
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= pkt_in;
                else
                    stage_q[s] <= stage_q[s-1];
            end
        end
        assign pkt_out = stage_q[STAGES-1];
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mac_pkt_t         pkt,
    output logic [ACC_W-1:0] acc_q,
    output logic             vld_q
);
    acc_op_e          op_now;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        op_now = pkt.vld ? pkt.op : ACC_HOLD;
        unique case (op_now)
            ACC_HOLD:  acc_d = acc_q;
            ACC_CLEAR: acc_d = '0;
            ACC_LOAD:  acc_d = pkt.term + pkt.casc;
            ACC_ADD:   acc_d = acc_q + pkt.term;
            default:   acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            vld_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            vld_q <= pkt.vld;
        end
    end

    // R1: quiet right after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_q == '0 && !vld_q));
    // R7: a clear leaves zero behind
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt.vld && pkt.op == ACC_CLEAR) |=> (acc_q == '0));
    // R6: an accumulate adds exactly the term, modulo 2^48
    p_add_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt.vld && pkt.op == ACC_ADD) |=> (acc_q - $past(acc_q) == $past(pkt.term)));
    // R9: no word, no change and no valid
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt.vld |=> (!vld_q && $stable(acc_q)));
endmodule

// File: rtl/preadd_mac.sv
module preadd_mac
    import mac_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    input  logic [OP_W-1:0]   d_in,
    input  logic              preadd_en,
    input  logic              coef_sel,
    input  logic [ROM_AW-1:0] coef_addr,
    input  logic              dot_mode,
    input  logic              acc_clear,
    input  logic              acc_load,
    input  logic              casc_en,
    input  logic [ACC_W-1:0]  casc_in,
    output logic [ACC_W-1:0]  result,
    output logic              out_valid,
    output logic [ACC_W-1:0]  casc_out
);
    logic [OP_W-1:0]  a_op, b_op;
    logic [ACC_W-1:0] term;
    mac_pkt_t         pkt_in, pkt_acc;

    mac_operand u_operand (
        .a_in(a_in), .b_in(b_in), .d_in(d_in),
        .preadd_en(preadd_en), .coef_sel(coef_sel), .coef_addr(coef_addr),
        .a_op(a_op), .b_op(b_op)
    );

    mac_multiply u_multiply (
        .a_op(a_op), .b_op(b_op), .dot_mode(dot_mode), .term(term)
    );

    always_comb begin
        pkt_in.vld  = in_valid;
        pkt_in.term = term;
        pkt_in.casc = '0;
        if (!in_valid)
            pkt_in.op = ACC_HOLD;
        else if (acc_clear)
            pkt_in.op = ACC_CLEAR;
        else if (acc_load) begin
            pkt_in.op = ACC_LOAD;
            if (casc_en)
                pkt_in.casc = casc_in;
        end else
            pkt_in.op = ACC_ADD;
    end

    mac_delay #(.STAGES(STAGES)) u_delay (
        .clk(clk), .rst_n(rst_n), .pkt_in(pkt_in), .pkt_out(pkt_acc)
    );

    mac_accum u_accum (
        .clk(clk), .rst_n(rst_n), .pkt(pkt_acc),
        .acc_q(result), .vld_q(out_valid)
    );

    assign casc_out = result;

    // R9: an accepted word always surfaces as out_valid after the delay line
    p_valid_reaches_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_acc.vld |=> out_valid);
    // R8: cascade value is never carried on an accumulate
    p_no_casc_on_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_clear && !acc_load) |-> (pkt_in.casc == '0));
endmodule

// File: tb/sim_preadd_mac.sv
module sim_preadd_mac;
    localparam int  CLK_PERIOD = 10;
    localparam int  LAT_STAGES = 2;
    localparam longint M48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] a_in = '0, b_in = '0, d_in = '0;
    logic        preadd_en = 1'b0, coef_sel = 1'b0, dot_mode = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic        acc_clear = 1'b0, acc_load = 1'b0, casc_en = 1'b0;
    logic [47:0] casc_in = '0;
    logic [47:0] result, casc_out;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    preadd_mac #(.STAGES(LAT_STAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .d_in(d_in),
        .preadd_en(preadd_en), .coef_sel(coef_sel), .coef_addr(coef_addr),
        .dot_mode(dot_mode), .acc_clear(acc_clear), .acc_load(acc_load),
        .casc_en(casc_en), .casc_in(casc_in),
        .result(result), .out_valid(out_valid), .casc_out(casc_out)
    );

    typedef struct {
        int          kind;   // 1 clear, 2 load, 3 add
        logic [47:0] term;
        logic [47:0] casc;
        string       tag;
    } ref_pkt_t;

    ref_pkt_t    pend[$];
    logic [47:0] m_acc = '0;
    bit          m_vld = 1'b0;
    string       m_tag = "R1";

    function automatic longint wrapw(longint v, int w);
        longint m;
        m = v & ((64'sd1 <<< w) - 1);
        if (m >= (64'sd1 <<< (w - 1))) m = m - (64'sd1 <<< w);
        return m;
    endfunction

    function automatic ref_pkt_t model_pkt();
        ref_pkt_t p;
        longint av, bv, t;
        av = longint'($signed(a_in));
        if (preadd_en) av = wrapw(av + longint'($signed(d_in)), 18);     // R3
        bv = coef_sel ? (64'sd7919 * longint'(coef_addr) - 64'sd50000)  // R4
                      : longint'($signed(b_in));
        if (dot_mode)                                                    // R5
            t = (av >>> 9) * (bv >>> 9) + wrapw(av, 9) * wrapw(bv, 9);
        else
            t = av * bv;                                                 // R2
        p.term = t[47:0];
        p.casc = '0;
        if (acc_clear) begin p.kind = 1; p.tag = "R7"; end
        else if (acc_load) begin
            p.kind = 2;
            if (casc_en) begin p.casc = casc_in; p.tag = "R8"; end
            else p.tag = dot_mode ? "R5" : coef_sel ? "R4" : preadd_en ? "R3" : "R2";
        end else begin
            p.kind = 3;
            p.tag = "R6";
        end
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            m_acc = '0;
            m_vld = 1'b0;
            m_tag = "R1";
        end else begin
            ref_pkt_t p, q;
            bit       pv;
            pv = in_valid;
            if (pv) p = model_pkt();
            else begin p.kind = 0; p.term = '0; p.casc = '0; p.tag = "R9"; end
            pend.push_back(p);
            m_vld = 1'b0;
            m_tag = "R9";
            if (pend.size() > LAT_STAGES) begin
                q = pend.pop_front();
                if (q.kind != 0) begin
                    m_vld = 1'b1;
                    m_tag = q.tag;
                    case (q.kind)
                        1: m_acc = '0;
                        2: m_acc = q.term + q.casc;
                        default: m_acc = m_acc + q.term;
                    endcase
                end
            end
        end
    end

    task automatic check48(string tag, logic [47:0] act, logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check48(m_tag, result, m_acc);
            check1("R9", out_valid, m_vld);
            check48("R10", casc_out, m_acc);
        end
    end

    task automatic drive(bit v, logic [17:0] a, logic [17:0] b, logic [17:0] d,
                         bit pre, bit cs, logic [3:0] ad, bit dm,
                         bit clr, bit ld, bit ce, logic [47:0] cin);
        @(negedge clk);
        in_valid = v; a_in = a; b_in = b; d_in = d;
        preadd_en = pre; coef_sel = cs; coef_addr = ad; dot_mode = dm;
        acc_clear = clr; acc_load = ld; casc_en = ce; casc_in = cin;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, '0, '0, '0, 0, 0, '0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check48("R1", result, '0);      // R1 during reset
        check1("R1", out_valid, 1'b0);
        check48("R1", casc_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R2: plain products, extremes included
        drive(1, 18'h20000, 18'h20000, '0, 0, 0, '0, 0, 0, 1, 0, '0);
        drive(1, 18'h1FFFF, 18'h20000, '0, 0, 0, '0, 0, 0, 1, 0, '0);
        drive(1, 18'd1234, 18'h3FFFF, '0, 0, 0, '0, 0, 0, 1, 0, '0);
        // R3: pre-adder wrap and negative sum
        drive(1, 18'h1FFFF, 18'd3, 18'd1, 1, 0, '0, 0, 0, 1, 0, '0);
        drive(1, 18'h20000, 18'd5, 18'h3FFFF, 1, 0, '0, 0, 0, 1, 0, '0);
        // R4: every table entry
        for (int k = 0; k < 16; k++)
            drive(1, 18'd3, 18'h15555, '0, 0, 1, k[3:0], 0, 0, 1, 0, '0);
        // R5: dot product, and combined with pre-add and table
        drive(1, 18'h20100, 18'h20100, '0, 0, 0, '0, 1, 0, 1, 0, '0);
        drive(1, 18'h0FFFF, 18'h3FEFF, 18'd77, 1, 1, 4'd9, 1, 0, 1, 0, '0);
        // R7: clear with load and cascade in the same word
        drive(1, 18'd9, 18'd9, '0, 0, 0, '0, 0, 1, 1, 1, 48'h1234);
        // R8: cascade near full, then R6 wrap past 2^48
        drive(1, 18'd2, 18'd3, '0, 0, 0, '0, 0, 0, 1, 1, 48'hFFFF_FFFF_FFF0);
        drive(1, 18'd5, 18'd4, '0, 0, 0, '0, 0, 0, 0, 1, 48'h7777);
        drive(1, 18'd1, 18'd1, '0, 0, 0, '0, 0, 0, 0, 0, 48'hAAAA);
        idle(LAT_STAGES + 3);
        // R9: sparse words and long holds
        drive(1, 18'd100, 18'd100, '0, 0, 0, '0, 0, 0, 0, 0, '0);
        idle(1);
        drive(1, 18'd7, 18'h3FFF0, '0, 0, 0, '0, 0, 0, 0, 0, '0);
        idle(6);
        // mixed traffic
        for (int i = 0; i < 3000; i++)
            drive($urandom_range(0, 3) != 0, 18'($urandom), 18'($urandom), 18'($urandom),
                  1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
                  $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0, 1'($urandom),
                  {16'($urandom), 32'($urandom)});
        idle(LAT_STAGES + 4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule